// File: doc/BRIEF.md
# Two-Master Locking Arbiter

This block shares a single memory port between two bus masters. Each master drives a request, an address and a write flag. Every cycle the arbiter picks at most one winner. It registers a one-hot grant and passes the winner's address and write flag to the memory side one clock later.

Arbitration between contending masters is round-robin. There are two exceptions, each switched on by its own static enable. The first keeps the grant with the master that won last time when its new access is the next beat of a burst: same direction, address one higher. The second keeps the grant when the new access is the write that follows a read of the same address. Both exceptions apply only when the previous cycle also carried a granted access. The block keeps a small history register set for these decisions: the last winner, its address and direction, and a back-to-back flag.

Top module: `lock_arbiter2`

## Requirements
- R1: The grant output `gnt` is one-hot or zero. Bit 0 means master 0 and bit 1 means master 1. It is registered, so a request sampled at a clock edge shows up in `gnt` right after that edge.
- R2: Only a master that requested in the sampled cycle is granted. When neither master requests, `gnt` is 2'b00 and `fwd_addr` and `fwd_wr` are zero.
- R3: When exactly one master requests, that master is granted, whatever the history.
- R4: When both masters request and no lock holds, the master other than the most recent winner is granted. With no winner since reset, master 0 is granted.
- R5: Alongside a grant, `fwd_addr` and `fwd_wr` carry the address and write flag that the granted master drove in the sampled cycle.
- R6: With `burst_lock_en` high, the most recent winner keeps the grant over a competing request when three conditions hold: the previous cycle was granted, its address equals the last granted address plus one, and its write flag equals the last granted write flag.
- R7: With `rmw_lock_en` high, the most recent winner keeps the grant over a competing request when four conditions hold: the previous cycle was granted, its address equals the last granted address, it is writing, and the last granted access was a read.
- R8: A cycle with no grant clears the back-to-back state. The access that follows such an idle cycle is arbitrated round-robin even if it continues a burst.
- R9: A lock applies only when its enable is high and all of its conditions match. A skipped address, a changed direction, or write-after-write falls back to round-robin. With both enables low the arbiter is always round-robin.
- R10: Synchronous active-high `rst` clears the grant, the forwarded outputs and the whole history. After reset the arbiter behaves as if no master had ever been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_req | input | 1 | Master 0 access request |
| m0_addr | input | ADDR_W | Master 0 address |
| m0_wr | input | 1 | Master 0 write flag (1 = write) |
| m1_req | input | 1 | Master 1 access request |
| m1_addr | input | ADDR_W | Master 1 address |
| m1_wr | input | 1 | Master 1 write flag (1 = write) |
| burst_lock_en | input | 1 | Static enable for holding across burst beats |
| rmw_lock_en | input | 1 | Static enable for holding a read-modify-write pair |
| gnt | output | 2 | Registered one-hot grant |
| fwd_addr | output | ADDR_W | Registered address of the granted access |
| fwd_wr | output | 1 | Registered write flag of the granted access |

## Verification
The hardest state to reach is a lock decision made while the other master is also requesting. Only in that situation does a hold give a different result from round-robin. The stimulus table first builds a granted history for one master. It then keeps both masters requesting on consecutive cycles, so the hold must override fairness. It next presents near-miss accesses right after held ones: a skipped address, a changed direction, write-after-write, locks disabled, and a burst beat after an idle cycle. Each of these shows the grant passing back to the other master. A reset in the middle of traffic then checks that the history no longer steers the round-robin choice.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int N_MST = 2;
  typedef logic [N_MST-1:0] mst_vec_t;

  // Round-robin alternative to a one-hot previous winner.
  function automatic mst_vec_t rr_other(input mst_vec_t prev);
    return {prev[0], prev[1]};
  endfunction
endpackage

// File: rtl/arb_lock_eval.sv
module arb_lock_eval
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  mst_vec_t                      last_master,
  input  mst_vec_t                      req_v,
  input  logic [N_MST-1:0][ADDR_W-1:0]  addr_v,
  input  mst_vec_t                      wr_v,
  input  logic [ADDR_W-1:0]             last_addr,
  input  logic                          last_wr,
  input  logic                          b2b,
  input  logic                          burst_en,
  input  logic                          rmw_en,
  output logic                          hold
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              cur_req;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr;
  logic              burst_hit;
  logic              rmw_hit;

  // Access currently offered by the previous winner.
  always_comb begin
    cur_req  = 1'b0;
    cur_addr = '0;
    cur_wr   = 1'b0;
    if (last_master[0]) begin
      cur_req  = req_v[0];
      cur_addr = addr_v[0];
      cur_wr   = wr_v[0];
    end else if (last_master[1]) begin
      cur_req  = req_v[1];
      cur_addr = addr_v[1];
      cur_wr   = wr_v[1];
    end
  end

  // Decision restarts from "release" every cycle: pure logic, no storage.
  always_comb begin
    burst_hit = 1'b0;
    rmw_hit   = 1'b0;
    hold      = 1'b0;
    if (b2b && cur_req) begin
      if (burst_en && (cur_addr == last_addr + ONE) && (cur_wr == last_wr))
        burst_hit = 1'b1;
      if (rmw_en && (cur_addr == last_addr) && cur_wr && !last_wr)
        rmw_hit = 1'b1;
      hold = burst_hit | rmw_hit;
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
  import arb_pkg::*;
(
  input  mst_vec_t req_v,
  input  mst_vec_t last_master,
  input  logic     hold,
  output mst_vec_t winner
);
  always_comb begin
    winner = '0;
    if (hold) begin
      winner = last_master;
    end else begin
      unique case (req_v)
        2'b01:   winner = 2'b01;
        2'b10:   winner = 2'b10;
        2'b11:   winner = (last_master == '0) ? 2'b01 : rr_other(last_master);
        default: winner = 2'b00;
      endcase
    end
  end
endmodule

// File: rtl/arb_history.sv
module arb_history
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  mst_vec_t          winner,
  input  logic [ADDR_W-1:0] win_addr,
  input  logic              win_wr,
  output mst_vec_t          last_master,
  output logic [ADDR_W-1:0] last_addr,
  output logic              last_wr,
  output logic              b2b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      last_master <= '0;
      last_addr   <= '0;
      last_wr     <= 1'b0;
      b2b         <= 1'b0;
    end else begin
      b2b <= |winner;
      if (|winner) begin
        last_master <= winner;
        last_addr   <= win_addr;
        last_wr     <= win_wr;
      end
    end
  end

  // A recorded winner must persist as a single master.
  assert_hist_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(last_master));
endmodule

// File: rtl/lock_arbiter2.sv
module lock_arbiter2
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m0_req,
  input  logic [ADDR_W-1:0] m0_addr,
  input  logic              m0_wr,
  input  logic              m1_req,
  input  logic [ADDR_W-1:0] m1_addr,
  input  logic              m1_wr,
  input  logic              burst_lock_en,
  input  logic              rmw_lock_en,
  output logic [1:0]        gnt,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_wr
);
  mst_vec_t                     req_v;
  mst_vec_t                     wr_v;
  logic [N_MST-1:0][ADDR_W-1:0] addr_v;
  mst_vec_t                     last_master;
  logic [ADDR_W-1:0]            last_addr;
  logic                         last_wr;
  logic                         b2b;
  logic                         hold;
  mst_vec_t                     winner;
  logic [ADDR_W-1:0]            win_addr;
  logic                         win_wr;

  assign req_v     = {m1_req, m0_req};
  assign wr_v      = {m1_wr, m0_wr};
  assign addr_v[0] = m0_addr;
  assign addr_v[1] = m1_addr;

  arb_lock_eval #(.ADDR_W(ADDR_W)) u_lock (
    .last_master (last_master),
    .req_v       (req_v),
    .addr_v      (addr_v),
    .wr_v        (wr_v),
    .last_addr   (last_addr),
    .last_wr     (last_wr),
    .b2b         (b2b),
    .burst_en    (burst_lock_en),
    .rmw_en      (rmw_lock_en),
    .hold        (hold)
  );

  arb_rr_pick u_pick (
    .req_v       (req_v),
    .last_master (last_master),
    .hold        (hold),
    .winner      (winner)
  );

  always_comb begin
    win_addr = '0;
    win_wr   = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (winner[i]) begin
        win_addr = addr_v[i];
        win_wr   = wr_v[i];
      end
    end
  end

  arb_history #(.ADDR_W(ADDR_W)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .winner      (winner),
    .win_addr    (win_addr),
    .win_wr      (win_wr),
    .last_master (last_master),
    .last_addr   (last_addr),
    .last_wr     (last_wr),
    .b2b         (b2b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt      <= '0;
      fwd_addr <= '0;
      fwd_wr   <= 1'b0;
    end else begin
      gnt      <= winner;
      fwd_addr <= win_addr;
      fwd_wr   <= win_wr;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(req_v) == 2'b00 |-> gnt == 2'b00 && fwd_addr == '0 && !fwd_wr);

  assert_single_wins_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(req_v) == 2'b01 || $past(req_v) == 2'b10) |-> gnt == $past(req_v));

  assert_rr_turn_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(req_v == 2'b11 && !hold && last_master != 2'b00)
    |-> gnt == {$past(last_master[0]), $past(last_master[1])});

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(hold) |-> gnt == $past(last_master));

  assert_b2b_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    b2b == (|gnt));

  assert_no_lock_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(!burst_lock_en && !rmw_lock_en && req_v == 2'b11 && last_master != 2'b00)
    |-> gnt == {$past(last_master[0]), $past(last_master[1])});

  assert_reset_clears_R10: assert property (@(posedge clk)
    $past(rst) && !rst |-> gnt == 2'b00 && fwd_addr == '0 && !fwd_wr && last_master == 2'b00);

  generate
    for (genvar g = 0; g < N_MST; g++) begin : g_chk
      assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && gnt[g] |-> $past(req_v[g]));
      assert_fwd_match_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && gnt[g] |-> fwd_addr == $past(addr_v[g]) && fwd_wr == $past(wr_v[g]));
    end
  endgenerate
endmodule

// File: tb/lock_arbiter2_tb.sv
`timescale 1ns/1ps
module lock_arbiter2_tb;
  localparam int AW = 16;
  localparam int NV = 14;

  typedef struct packed {
    logic          r0;
    logic [AW-1:0] a0;
    logic          w0;
    logic          r1;
    logic [AW-1:0] a1;
    logic          w1;
    logic          be;
    logic          re;
    logic [1:0]    eg;
    logic [AW-1:0] ea;
    logic          ew;
    logic [7:0]    tag;
  } vec_t;

  // r0 a0 w0 | r1 a1 w1 | be re | exp gnt, addr, wr | requirement
  localparam vec_t VECS [NV] = '{
    '{1'b1,16'h0010,1'b0, 1'b1,16'h0020,1'b0, 1'b1,1'b1, 2'b01,16'h0010,1'b0, 8'd4}, // R4 fresh: m0
    '{1'b1,16'h0011,1'b0, 1'b1,16'h0020,1'b0, 1'b1,1'b1, 2'b01,16'h0011,1'b0, 8'd6}, // R6 burst beat held
    '{1'b1,16'h0012,1'b0, 1'b1,16'h0020,1'b0, 1'b1,1'b1, 2'b01,16'h0012,1'b0, 8'd6}, // R6 held again
    '{1'b1,16'h0014,1'b0, 1'b1,16'h0020,1'b0, 1'b1,1'b1, 2'b10,16'h0020,1'b0, 8'd9}, // R9 skipped addr
    '{1'b1,16'h0030,1'b0, 1'b1,16'h0020,1'b1, 1'b1,1'b1, 2'b10,16'h0020,1'b1, 8'd7}, // R7 rmw write held
    '{1'b1,16'h0030,1'b0, 1'b1,16'h0020,1'b1, 1'b1,1'b1, 2'b01,16'h0030,1'b0, 8'd9}, // R9 write after write
    '{1'b0,16'h0000,1'b0, 1'b0,16'h0000,1'b0, 1'b1,1'b1, 2'b00,16'h0000,1'b0, 8'd2}, // R2 idle
    '{1'b1,16'h0031,1'b0, 1'b1,16'h0040,1'b0, 1'b1,1'b1, 2'b10,16'h0040,1'b0, 8'd8}, // R8 no lock after idle
    '{1'b0,16'h0000,1'b0, 1'b1,16'h0041,1'b0, 1'b0,1'b0, 2'b10,16'h0041,1'b0, 8'd3}, // R3 lone m1
    '{1'b1,16'h0050,1'b0, 1'b1,16'h0042,1'b0, 1'b0,1'b0, 2'b01,16'h0050,1'b0, 8'd9}, // R9 locks off
    '{1'b1,16'h0050,1'b1, 1'b1,16'h0060,1'b0, 1'b1,1'b0, 2'b10,16'h0060,1'b0, 8'd9}, // R9 rmw disabled
    '{1'b1,16'h0070,1'b0, 1'b1,16'h0061,1'b1, 1'b1,1'b1, 2'b01,16'h0070,1'b0, 8'd9}, // R9 dir change
    '{1'b1,16'h0080,1'b1, 1'b0,16'h0000,1'b0, 1'b1,1'b1, 2'b01,16'h0080,1'b1, 8'd3}, // R3 lone m0 write
    '{1'b0,16'h0081,1'b1, 1'b1,16'h0090,1'b0, 1'b1,1'b1, 2'b10,16'h0090,1'b0, 8'd3}  // R3 last winner idle
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          m0_req, m0_wr, m1_req, m1_wr, burst_lock_en, rmw_lock_en;
  logic [AW-1:0] m0_addr, m1_addr;
  logic [1:0]    gnt;
  logic [AW-1:0] fwd_addr;
  logic          fwd_wr;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  always #2.5 clk = ~clk;

  lock_arbiter2 #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .m0_req(m0_req), .m0_addr(m0_addr), .m0_wr(m0_wr),
    .m1_req(m1_req), .m1_addr(m1_addr), .m1_wr(m1_wr),
    .burst_lock_en(burst_lock_en), .rmw_lock_en(rmw_lock_en),
    .gnt(gnt), .fwd_addr(fwd_addr), .fwd_wr(fwd_wr)
  );

  task automatic drive(input logic r0, input logic [AW-1:0] a0, input logic w0,
                       input logic r1, input logic [AW-1:0] a1, input logic w1,
                       input logic be, input logic re);
    m0_req = r0; m0_addr = a0; m0_wr = w0;
    m1_req = r1; m1_addr = a1; m1_wr = w1;
    burst_lock_en = be; rmw_lock_en = re;
  endtask

  task automatic check(input string req, input logic [1:0] eg,
                       input logic [AW-1:0] ea, input logic ew);
    n_tests++;
    if (gnt !== eg || fwd_addr !== ea || fwd_wr !== ew) begin
      n_fail++;
      $display("FAIL %s: gnt=%b addr=%h wr=%b expected gnt=%b addr=%h wr=%b",
               req, gnt, fwd_addr, fwd_wr, eg, ea, ew);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 16'h0001, 1'b0, 1'b1, 16'h0002, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 reset state", 2'b00, '0, 1'b0);
    rst = 1'b0;

    // Table walk: drive at a falling edge, check at the next falling edge.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].r0, VECS[i].a0, VECS[i].w0, VECS[i].r1, VECS[i].a1, VECS[i].w1,
            VECS[i].be, VECS[i].re);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].tag, i), VECS[i].eg, VECS[i].ea, VECS[i].ew);
    end

    // Directed: history made by m0, then reset mid-traffic.
    drive(1'b1, 16'h0005, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R3 lone m0 before reset", 2'b01, 16'h0005, 1'b0);
    drive(1'b1, 16'h0006, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset during traffic", 2'b00, '0, 1'b0);
    rst = 1'b0;
    drive(1'b1, 16'h0007, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R10 history cleared, m0 first", 2'b01, 16'h0007, 1'b0);
    drive(1'b1, 16'h0009, 1'b0, 1'b1, 16'h0009, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R4 alternation after reset", 2'b10, 16'h0009, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule